// File: doc/BRIEF.md
# Transmit Video Timing Generator

This block paces a transmit-side packed pixel interface. It takes a set of programmable timing values and produces three control outputs. A frame-level sync is high across each valid frame. A line-level sync is high for each valid line. A valid strobe marks every clock on which a packed word is sent. Horizontal timing is counted in clocks and vertical timing in whole lines. Each line slot is made of four segments in this order: sync gap, back porch, active words and front porch. Each frame is made of four line groups in this order: sync lines, back-porch lines, active lines and front-porch lines.

Software can write the timing values and the side-band fields (horizontal resolution, data type, virtual channel) at any time through a write strobe. A write only fills a shadow copy. The timing values reach the counters at the next frame start. Resolution and type reach their outputs at the next line start. The channel reaches its output at the next frame start. So each output field changes only while its sync is low, and well before that sync rises again. A data-request strobe runs one clock ahead of valid, so that a registered packer can deliver one word on every valid clock.

Top module: `vtg_top`

## Requirements
- R1: After reset every output is low or zero. The shadow timing then holds the minimum values: 2 clocks for each horizontal blank segment, 1 active word, and 1 line for each vertical group.
- R2: With the block idle, enable sampled high at a clock edge starts a frame at that edge. The first frame clock shows frame sync low, and it is the first clock of the first line slot.
- R3: A frame spans (sync + back + active + front) lines of (sync + back + words + front) clocks each. Frame sync is low during the sync lines and high for the rest of the frame. Line sync is high only in active lines, from the end of the horizontal sync gap to the end of the line slot.
- R4: In every active line, valid rises after the sync gap plus the back porch, stays high for exactly the active word count with no gap, and is never high outside an active line.
- R5: The data request is high in exactly the clocks that come one clock before a clock with valid high.
- R6: Written horizontal sync, back and front values below 2 count as 2. Vertical values and active counts below 1 count as 1.
- R7: Horizontal resolution and data type take their shadow values only at the first clock of a line slot inside a frame. They therefore change only while line sync is low, and at least 2 clocks before line sync rises.
- R8: The virtual channel output takes its shadow value only at the first clock of a frame. It therefore changes only while frame sync is low.
- R9: A configuration write is captured into shadow storage at once. Timing values do not affect the frame in progress; they apply from the next frame start.
- R10: When enable is low at the last clock of a frame, that frame completes and the block returns to idle, with frame sync, line sync, valid and data request all low, until enable is seen again.
- R11: When enable is high at the last clock of a frame, the next frame starts on the following clock with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run request; checked while idle and at each frame end |
| cfg_wr | input | 1 | Captures all cfg_* inputs into the shadow copy |
| cfg_h_active | input | H_W | Active words per line |
| cfg_h_sync | input | H_W | Horizontal sync gap in clocks |
| cfg_h_back | input | H_W | Horizontal back porch in clocks |
| cfg_h_front | input | H_W | Horizontal front porch in clocks |
| cfg_v_active | input | V_W | Active lines per frame |
| cfg_v_sync | input | V_W | Vertical sync in lines |
| cfg_v_back | input | V_W | Vertical back porch in lines |
| cfg_v_front | input | V_W | Vertical front porch in lines |
| cfg_hres | input | RES_W | Horizontal resolution value to present |
| cfg_dtype | input | DT_W | Data type code to present |
| cfg_vc | input | VC_W | Virtual channel to present |
| frame_sync_o | output | 1 | High across the valid frame |
| line_sync_o | output | 1 | High for each valid line |
| valid_o | output | 1 | High on each word clock of an active line |
| data_req_o | output | 1 | High one clock before each valid clock |
| hres_o | output | RES_W | Resolution, updated at line starts |
| dtype_o | output | DT_W | Data type, updated at line starts |
| vc_o | output | VC_W | Virtual channel, updated at frame starts |

## Verification
The sync, valid, resolution, type and channel outputs are registered. Each one shows the state entered at a clock edge during the clock that follows that edge. The data request is decoded from the next state, so it leads valid by exactly one clock. A frame requested by enable shows its first clock in the cycle right after the edge that samples enable. For each clock it drives, the bench computes the expected outputs from frame position, line length and frame length. It stamps each expected item with the edge count after which the item is due. The monitor compares an item only at the falling edge of that cycle, so every comparison lands on the clock where the result must appear.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Segment order inside a line slot; the value doubles as the length index.
  typedef enum logic [1:0] {
    HP_SYNC  = 2'd0,
    HP_BACK  = 2'd1,
    HP_ACT   = 2'd2,
    HP_FRONT = 2'd3
  } hphase_t;

  // Line-group order inside a frame; low two bits index the length table.
  typedef enum logic [2:0] {
    VP_SYNC  = 3'd0,
    VP_BACK  = 3'd1,
    VP_ACT   = 3'd2,
    VP_FRONT = 3'd3,
    VP_IDLE  = 3'd4
  } vphase_t;

  localparam int N_SEG   = 4;
  localparam int SEG_ACT = 2;

endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
#(
  parameter int W         = 16,
  parameter int BLANK_MIN = 2,
  parameter int ACT_MIN   = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] seg_raw [N_SEG],
  output logic [W-1:0] seg_q   [N_SEG]
);

  // One clamped holding register per segment length.
  for (genvar i = 0; i < N_SEG; i++) begin : g_seg
    localparam logic [W-1:0] FLOOR = (i == SEG_ACT) ? W'(ACT_MIN) : W'(BLANK_MIN);

    logic [W-1:0] len_d;
    logic [W-1:0] len_q;

    always_comb begin
      len_d = (seg_raw[i] < FLOOR) ? FLOOR : seg_raw[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q <= FLOOR;
      end else if (wr_en) begin
        len_q <= len_d;
      end
    end

    assign seg_q[i] = len_q;
  end

endmodule

// File: rtl/vtg_hseq.sv
module vtg_hseq
  import vtg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] seg_len [N_SEG],
  output hphase_t      phase_d,
  output logic         line_end
);

  hphase_t      phase_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         seg_last;

  always_comb begin
    seg_last = (cnt_q == (seg_len[phase_q] - W'(1)));
    line_end = run && (phase_q == HP_FRONT) && seg_last;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    if (!run) begin
      phase_d = HP_SYNC;
      cnt_d   = '0;
    end else if (seg_last) begin
      phase_d = hphase_t'(phase_q + 2'd1);
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= HP_SYNC;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/vtg_vseq.sv
module vtg_vseq
  import vtg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         line_end,
  input  logic [W-1:0] seg_len [N_SEG],
  output vphase_t      phase_q,
  output vphase_t      phase_d,
  output logic         frame_load
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         grp_last;

  always_comb begin
    grp_last   = (cnt_q == (seg_len[phase_q[1:0]] - W'(1)));
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    frame_load = 1'b0;
    if (phase_q == VP_IDLE) begin
      if (enable) begin
        phase_d    = VP_SYNC;
        cnt_d      = '0;
        frame_load = 1'b1;
      end
    end else if (line_end) begin
      if (grp_last) begin
        cnt_d = '0;
        if (phase_q == VP_FRONT) begin
          if (enable) begin
            phase_d    = VP_SYNC;
            frame_load = 1'b1;
          end else begin
            phase_d = VP_IDLE;
          end
        end else begin
          phase_d = vphase_t'(phase_q + 3'd1);
        end
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= VP_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int H_W       = 16,
  parameter int V_W       = 12,
  parameter int RES_W     = 16,
  parameter int DT_W      = 6,
  parameter int VC_W      = 2,
  parameter int H_MIN     = 2,
  parameter int V_MIN     = 1,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_wr,
  input  logic [H_W-1:0]   cfg_h_active,
  input  logic [H_W-1:0]   cfg_h_sync,
  input  logic [H_W-1:0]   cfg_h_back,
  input  logic [H_W-1:0]   cfg_h_front,
  input  logic [V_W-1:0]   cfg_v_active,
  input  logic [V_W-1:0]   cfg_v_sync,
  input  logic [V_W-1:0]   cfg_v_back,
  input  logic [V_W-1:0]   cfg_v_front,
  input  logic [RES_W-1:0] cfg_hres,
  input  logic [DT_W-1:0]  cfg_dtype,
  input  logic [VC_W-1:0]  cfg_vc,
  output logic             frame_sync_o,
  output logic             line_sync_o,
  output logic             valid_o,
  output logic             data_req_o,
  output logic [RES_W-1:0] hres_o,
  output logic [DT_W-1:0]  dtype_o,
  output logic [VC_W-1:0]  vc_o
);

  // ---------------- reset: async assert, synchronous release ----------------
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[RST_STAGES-1];

  // ---------------- shadow storage ----------------
  logic [H_W-1:0] h_raw [N_SEG];
  logic [V_W-1:0] v_raw [N_SEG];
  logic [H_W-1:0] h_sh  [N_SEG];
  logic [V_W-1:0] v_sh  [N_SEG];

  assign h_raw[HP_SYNC]  = cfg_h_sync;
  assign h_raw[HP_BACK]  = cfg_h_back;
  assign h_raw[HP_ACT]   = cfg_h_active;
  assign h_raw[HP_FRONT] = cfg_h_front;
  assign v_raw[0]        = cfg_v_sync;
  assign v_raw[1]        = cfg_v_back;
  assign v_raw[2]        = cfg_v_active;
  assign v_raw[3]        = cfg_v_front;

  vtg_shadow #(.W(H_W), .BLANK_MIN(H_MIN), .ACT_MIN(1)) u_h_shadow (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_wr),
    .seg_raw (h_raw),
    .seg_q   (h_sh)
  );

  vtg_shadow #(.W(V_W), .BLANK_MIN(V_MIN), .ACT_MIN(1)) u_v_shadow (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_wr),
    .seg_raw (v_raw),
    .seg_q   (v_sh)
  );

  logic [RES_W-1:0] sh_hres;
  logic [DT_W-1:0]  sh_dtype;
  logic [VC_W-1:0]  sh_vc;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sh_hres  <= '0;
      sh_dtype <= '0;
      sh_vc    <= '0;
    end else if (cfg_wr) begin
      sh_hres  <= cfg_hres;
      sh_dtype <= cfg_dtype;
      sh_vc    <= cfg_vc;
    end
  end

  // ---------------- working timing, frozen per frame ----------------
  logic [H_W-1:0] h_len [N_SEG];
  logic [V_W-1:0] v_len [N_SEG];
  logic           frame_load;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < N_SEG; i++) begin
        h_len[i] <= '0;
        v_len[i] <= '0;
      end
    end else if (frame_load) begin
      for (int i = 0; i < N_SEG; i++) begin
        h_len[i] <= h_sh[i];
        v_len[i] <= v_sh[i];
      end
    end
  end

  // ---------------- sequencers ----------------
  vphase_t v_phase_q;
  vphase_t v_phase_d;
  hphase_t h_phase_d;
  logic    line_end;
  logic    frame_run;

  assign frame_run = (v_phase_q != VP_IDLE);

  vtg_hseq #(.W(H_W)) u_hseq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (frame_run),
    .seg_len  (h_len),
    .phase_d  (h_phase_d),
    .line_end (line_end)
  );

  vtg_vseq #(.W(V_W)) u_vseq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .enable     (enable),
    .line_end   (line_end),
    .seg_len    (v_len),
    .phase_q    (v_phase_q),
    .phase_d    (v_phase_d),
    .frame_load (frame_load)
  );

  // ---------------- output decode of the next state ----------------
  logic fs_d;
  logic ls_d;
  logic va_d;
  logic line_load;

  always_comb begin
    fs_d      = (v_phase_d != VP_IDLE) && (v_phase_d != VP_SYNC);
    ls_d      = (v_phase_d == VP_ACT) && (h_phase_d != HP_SYNC);
    va_d      = (v_phase_d == VP_ACT) && (h_phase_d == HP_ACT);
    line_load = frame_load || (line_end && (v_phase_d != VP_IDLE));
  end

  assign data_req_o = va_d;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      frame_sync_o <= 1'b0;
      line_sync_o  <= 1'b0;
      valid_o      <= 1'b0;
    end else begin
      frame_sync_o <= fs_d;
      line_sync_o  <= ls_d;
      valid_o      <= va_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hres_o  <= '0;
      dtype_o <= '0;
    end else if (line_load) begin
      hres_o  <= sh_hres;
      dtype_o <= sh_dtype;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vc_o <= '0;
    end else if (frame_load) begin
      vc_o <= sh_vc;
    end
  end

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int RES_W = 16,
  parameter int DT_W  = 6,
  parameter int VC_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_sync_o,
  input logic             line_sync_o,
  input logic             valid_o,
  input logic             data_req_o,
  input logic [RES_W-1:0] hres_o,
  input logic [DT_W-1:0]  dtype_o,
  input logic [VC_W-1:0]  vc_o
);

  // R3
  line_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_sync_o |-> frame_sync_o);

  // R4
  valid_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> line_sync_o);

  // R4
  valid_ends_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> line_sync_o);

  // R4
  valid_after_porch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(line_sync_o));

  // R5
  req_leads_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req_o |=> valid_o);

  // R5
  valid_was_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(data_req_o));

  // R6
  line_gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_sync_o) |=> !line_sync_o);

  // R7
  line_fields_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hres_o) || !$stable(dtype_o)) |-> !line_sync_o);

  // R7
  line_fields_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_sync_o) |-> ($stable(hres_o) && $stable(dtype_o)));

  // R8
  chan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vc_o) |-> !frame_sync_o);

  // R8
  chan_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_sync_o) |-> $stable(vc_o));

endmodule

bind vtg_top vtg_checker #(.RES_W(RES_W), .DT_W(DT_W), .VC_W(VC_W)) u_vtg_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_sync_o (frame_sync_o),
  .line_sync_o  (line_sync_o),
  .valid_o      (valid_o),
  .data_req_o   (data_req_o),
  .hres_o       (hres_o),
  .dtype_o      (dtype_o),
  .vc_o         (vc_o)
);

// File: tb/tb_vtg_top.sv
module tb_vtg_top;

  localparam int HW = 16;
  localparam int VW = 12;
  localparam int RW = 16;
  localparam int DW = 6;
  localparam int CW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, enable, cfg_wr;
  logic [HW-1:0] cfg_h_active, cfg_h_sync, cfg_h_back, cfg_h_front;
  logic [VW-1:0] cfg_v_active, cfg_v_sync, cfg_v_back, cfg_v_front;
  logic [RW-1:0] cfg_hres;
  logic [DW-1:0] cfg_dtype;
  logic [CW-1:0] cfg_vc;
  logic          frame_sync_o, line_sync_o, valid_o, data_req_o;
  logic [RW-1:0] hres_o;
  logic [DW-1:0] dtype_o;
  logic [CW-1:0] vc_o;

  vtg_top dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_h_active(cfg_h_active), .cfg_h_sync(cfg_h_sync),
    .cfg_h_back(cfg_h_back), .cfg_h_front(cfg_h_front),
    .cfg_v_active(cfg_v_active), .cfg_v_sync(cfg_v_sync),
    .cfg_v_back(cfg_v_back), .cfg_v_front(cfg_v_front),
    .cfg_hres(cfg_hres), .cfg_dtype(cfg_dtype), .cfg_vc(cfg_vc),
    .frame_sync_o(frame_sync_o), .line_sync_o(line_sync_o),
    .valid_o(valid_o), .data_req_o(data_req_o),
    .hres_o(hres_o), .dtype_o(dtype_o), .vc_o(vc_o)
  );

  typedef struct {
    bit fs, ls, va, rq;
    int hr, dt, vc;
    int due;
  } exp_t;

  exp_t  sbq[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 0;
  string tag = "R1";

  // Model: index 0 words, 1 hsync, 2 hback, 3 hfront, 4 lines, 5 vsync, 6 vback, 7 vfront
  int sh[8];
  int wk[8];
  int sh_hr, sh_dt, sh_vc;
  int m_hr, m_dt, m_vc;
  bit m_run;
  int m_idx;
  int b_cfg[8];
  int b_hr, b_dt, b_vc;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clampi(int v, int lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic int line_len();
    return wk[1] + wk[2] + wk[0] + wk[3];
  endfunction

  function automatic int frame_len();
    return line_len() * (wk[5] + wk[6] + wk[4] + wk[7]);
  endfunction

  function automatic void pos(input int idx, output bit vs, output bit hs, output bit va);
    int ht, l, c, a0;
    bit al;
    ht = line_len();
    l  = idx / ht;
    c  = idx % ht;
    a0 = wk[5] + wk[6];
    vs = (l >= wk[5]);
    al = (l >= a0) && (l < a0 + wk[4]);
    hs = al && (c >= wk[1]);
    va = al && (c >= wk[1] + wk[2]) && (c < wk[1] + wk[2] + wk[0]);
  endfunction

  function automatic void load_frame();
    for (int i = 0; i < 8; i++) wk[i] = sh[i];
    m_vc = sh_vc; m_hr = sh_hr; m_dt = sh_dt;
  endfunction

  function automatic void model_step(bit en, bit wr);
    exp_t e;
    bit vs, hs, va, nvs, nhs, nva;
    if (!m_run) begin
      if (en) begin m_run = 1; m_idx = 0; load_frame(); end
    end else if (m_idx + 1 == frame_len()) begin
      if (en) begin m_idx = 0; load_frame(); end
      else begin m_run = 0; m_idx = 0; end
    end else begin
      m_idx++;
      if (m_idx % line_len() == 0) begin m_hr = sh_hr; m_dt = sh_dt; end
    end
    if (wr) begin
      sh[0] = clampi(b_cfg[0], 1);
      for (int i = 1; i < 4; i++) sh[i] = clampi(b_cfg[i], 2);
      for (int i = 4; i < 8; i++) sh[i] = clampi(b_cfg[i], 1);
      sh_hr = b_hr; sh_dt = b_dt; sh_vc = b_vc;
    end
    if (m_run) begin
      pos(m_idx, vs, hs, va);
      if (m_idx + 1 < frame_len()) pos(m_idx + 1, nvs, nhs, nva);
      else nva = 0;
    end else begin
      vs = 0; hs = 0; va = 0; nva = 0;
    end
    e.fs = vs; e.ls = hs; e.va = va; e.rq = nva;
    e.hr = m_hr; e.dt = m_dt; e.vc = m_vc;
    e.due = cyc + 1;
    sbq.push_back(e);
  endfunction

  task automatic set_cfg(int words, int hs, int hb, int hf, int lines, int vs, int vb, int vf,
                         int hr, int dt, int vc);
    b_cfg[0] = words; b_cfg[1] = hs; b_cfg[2] = hb; b_cfg[3] = hf;
    b_cfg[4] = lines; b_cfg[5] = vs; b_cfg[6] = vb; b_cfg[7] = vf;
    b_hr = hr; b_dt = dt; b_vc = vc;
    cfg_h_active = HW'(words); cfg_h_sync = HW'(hs); cfg_h_back = HW'(hb); cfg_h_front = HW'(hf);
    cfg_v_active = VW'(lines); cfg_v_sync = VW'(vs); cfg_v_back = VW'(vb); cfg_v_front = VW'(vf);
    cfg_hres = RW'(hr); cfg_dtype = DW'(dt); cfg_vc = CW'(vc);
  endtask

  // Driver: sets inputs for the coming edge and pushes the outputs due after it.
  task automatic tick(input bit en, input bit wr);
    @(posedge clk); #1;
    enable = en; cfg_wr = wr;
    model_step(en, wr);
  endtask

  task automatic cmp(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: got %0h expected %0h (cycle %0d)", req, tag, what, act, exp, cyc);
    end
  endtask

  // Monitor: pops each item on the cycle it is due.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      e = sbq.pop_front();
      cmp(int'(frame_sync_o), int'(e.fs), "R3", "frame_sync");
      cmp(int'(line_sync_o),  int'(e.ls), "R3", "line_sync");
      cmp(int'(valid_o),      int'(e.va), "R4", "valid");
      cmp(int'(data_req_o),   int'(e.rq), "R5", "data_req");
      cmp(int'(hres_o),       e.hr,       "R7", "hres");
      cmp(int'(dtype_o),      e.dt,       "R7", "dtype");
      cmp(int'(vc_o),         e.vc,       "R8", "vc");
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete (cycle %0d)", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; cfg_wr = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    sh[0] = 1; sh[1] = 2; sh[2] = 2; sh[3] = 2;
    sh[4] = 1; sh[5] = 1; sh[6] = 1; sh[7] = 1;
    for (int i = 0; i < 8; i++) wk[i] = sh[i];
    sh_hr = 0; sh_dt = 0; sh_vc = 0;
    m_hr = 0; m_dt = 0; m_vc = 0; m_run = 0; m_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    tag = "R1";
    cmp(int'(frame_sync_o), 0, "R1", "frame_sync after reset");
    cmp(int'(line_sync_o),  0, "R1", "line_sync after reset");
    cmp(int'(valid_o),      0, "R1", "valid after reset");
    cmp(int'(data_req_o),   0, "R1", "data_req after reset");
    cmp(int'(hres_o),       0, "R1", "hres after reset");
    cmp(int'(dtype_o),      0, "R1", "dtype after reset");
    cmp(int'(vc_o),         0, "R1", "vc after reset");

    // R9: first configuration into the shadow, block idle
    tag = "R9";
    set_cfg(4, 2, 3, 2, 3, 1, 2, 1, 'h0100, 'h2A, 1);
    tick(0, 1);
    repeat (3) tick(0, 0);

    // R2: start from idle
    tag = "R2";
    tick(1, 0);
    tag = "R3";
    repeat (40) tick(1, 0);

    // R9: mid-frame write; timing waits for the next frame, fields for the next line
    tag = "R9";
    set_cfg(6, 3, 2, 4, 2, 2, 1, 2, 'h0200, 'h24, 2);
    tick(1, 1);
    repeat (20) tick(1, 0);

    // R11: frame boundary crossed with enable held
    tag = "R11";
    repeat (80) tick(1, 0);

    // R10: enable dropped inside a frame; that frame completes, then idle
    tag = "R10";
    repeat (120) tick(0, 0);
    @(negedge clk);
    cmp(int'(frame_sync_o | line_sync_o | valid_o | data_req_o), 0, "R10", "idle after drain");

    // R6: values below the minimums
    tag = "R6";
    set_cfg(0, 0, 1, 0, 0, 0, 0, 0, 'h0033, 'h2B, 3);
    tick(0, 1);
    tick(1, 0);
    repeat (60) tick(1, 0);
    tag = "R10";
    repeat (40) tick(0, 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp(sbq.size(), 0, "R3", "scoreboard drained");
    finish_run();
  end

endmodule